// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block keeps a 4-bit code in a small register and turns it into a one-of-sixteen select vector. While the pass enable is high, each clock loads the register from the code input. Once the enable drops, the register holds the last code loaded and ignores further changes on the code input. A blanking input forces every select line to its inactive level without disturbing the stored code. When blanking is released, the stored code shows again.

Everything is synchronous to one clock. The pass enable, code and blanking inputs are sampled on the rising edge, and the select vector is decoded from registered state. A change on any input therefore shows at the outputs one clock after the edge that sampled it. A compile-time parameter sets the output polarity: in active-high mode the selected line is 1 and the rest are 0, and in active-low mode every bit is inverted.

Top module: `latch_dec16`

## Requirements
- R1: On a rising edge where pass_en is 1, the stored code takes the value of code_in, and sel_out reflects it from that edge on.
- R2: On a rising edge where pass_en is 0, the stored code keeps its value, so changes on code_in have no effect on sel_out.
- R3: code_in bit 3 is the most significant bit of the code, and bit 0 is the least significant. A stored code of value n selects line sel_out[n], so 0 selects bit 0 and 15 selects bit 15.
- R4: With ACT_HIGH=1 and blanking off, the selected line is 1 and the other fifteen lines are 0.
- R5: With ACT_HIGH=0 and blanking off, the selected line is 0 and the other fifteen lines are 1.
- R6: One clock after blank is sampled as 1, every line sits at its inactive level: all 0 when ACT_HIGH=1, all 1 when ACT_HIGH=0. The code input and pass_en make no difference to this.
- R7: Blanking does not change the stored code. After blank returns to 0, the line selected by the stored code is active again.
- R8: A synchronous reset (rst=1 at a rising edge) clears the stored code to 0 and clears the registered blanking. After reset, line 0 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pass_en | input | 1 | 1: load the code each clock; 0: hold the stored code |
| code_in | input | 4 | Code to decode; bit 3 is the most significant bit |
| blank | input | 1 | 1: force all select lines inactive |
| sel_out | output | 16 | One-of-sixteen select vector, polarity set by ACT_HIGH |

## Verification
The bench walks through all sixteen codes on an active-high instance and an active-low instance side by side. A decoder with swapped code bits or an inverted polarity selects the wrong line on one of those codes. With pass_en low, the bench sweeps code_in through every value. A register that kept loading would let the outputs follow code_in during that sweep. The bench also asserts blank while the stored code should stay unchanged, then releases it. A design that let blanking clear the stored code would come back showing line 0 instead of the held line. Reset is applied in the middle of a run, so a reset that clears only the outputs, and not the stored code, shows up as soon as reset is released.

// File: rtl/latch_dec16.sv
module latch_dec16 #(
  parameter int SEL_W    = 4,
  parameter bit ACT_HIGH = 1'b1,
  localparam int NOUT    = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pass_en,
  input  logic [SEL_W-1:0] code_in,
  input  logic             blank,
  output logic [NOUT-1:0]  sel_out
);

  logic [SEL_W-1:0] code_q;
  logic             blank_q;
  logic [NOUT-1:0]  hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      blank_q <= 1'b0;
    end else begin
      if (pass_en) code_q <= code_in;
      blank_q <= blank;
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_line
    assign hot[i] = !blank_q && (code_q == SEL_W'(i));
  end

  if (ACT_HIGH) begin : g_hi
    assign sel_out = hot;
  end else begin : g_lo
    assign sel_out = ~hot;
  end

endmodule

// File: rtl/latch_dec16_chk.sv
module latch_dec16_chk #(
  parameter int SEL_W    = 4,
  parameter bit ACT_HIGH = 1'b1,
  localparam int NOUT    = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic             pass_en,
  input logic [SEL_W-1:0] code_in,
  input logic             blank,
  input logic [NOUT-1:0]  sel_out
);

  function automatic logic [NOUT-1:0] want(input logic [SEL_W-1:0] c);
    logic [NOUT-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return ACT_HIGH ? v : ~v;
  endfunction

  localparam logic [NOUT-1:0] IDLE = ACT_HIGH ? '0 : '1;

  // R1 R3 R4 R5
  load_shows_code_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_en && !blank) |=> (sel_out == want($past(code_in))));

  // R2
  hold_keeps_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!pass_en && !blank && $past(!blank) && $past(!rst)) |=> $stable(sel_out));

  // R6
  blank_idle_chk: assert property (@(posedge clk) disable iff (rst)
    blank |=> (sel_out == IDLE));

  // R4 R5
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    !blank |=> ($countones(ACT_HIGH ? sel_out : ~sel_out) == 1));

endmodule

bind latch_dec16 latch_dec16_chk #(.SEL_W(SEL_W), .ACT_HIGH(ACT_HIGH)) u_chk (
  .clk(clk), .rst(rst), .pass_en(pass_en), .code_in(code_in),
  .blank(blank), .sel_out(sel_out)
);

// File: tb/test_latch_dec16.sv
module test_latch_dec16;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pass_en = 1'b0;
  logic [3:0]  code_in = '0;
  logic        blank = 1'b0;
  logic [15:0] hi, lo;
  int          total = 0, failed = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  latch_dec16 #(.SEL_W(4), .ACT_HIGH(1'b1)) i_latch_dec16 (
    .clk(clk), .rst(rst), .pass_en(pass_en), .code_in(code_in),
    .blank(blank), .sel_out(hi));

  latch_dec16 #(.SEL_W(4), .ACT_HIGH(1'b0)) i_latch_dec16_lo (
    .clk(clk), .rst(rst), .pass_en(pass_en), .code_in(code_in),
    .blank(blank), .sel_out(lo));

  function automatic logic [15:0] expv(input int c, input bit b, input bit act_hi);
    logic [15:0] v;
    v = b ? 16'h0 : (16'h1 << c);
    return act_hi ? v : ~v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic chk(input string req, input int c, input bit b);
    total++;
    if (hi !== expv(c, b, 1'b1)) begin
      failed++;
      $display("FAIL %s active-high: got %h expected %h", req, hi, expv(c, b, 1'b1));
    end
    total++;
    if (lo !== expv(c, b, 1'b0)) begin
      failed++;
      $display("FAIL %s active-low: got %h expected %h", req, lo, expv(c, b, 1'b0));
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    code_in = 4'd11;
    pass_en = 1'b0;
    tick(); tick();
    chk("R8 reset state", 0, 1'b0);
    rst = 1'b0;

    // R1 R3 R4 R5: every code, both polarities
    pass_en = 1'b1;
    for (int c = 0; c < 16; c++) begin
      code_in = 4'(c);
      tick();
      chk("R1 R3 R4 R5 load", c, 1'b0);
    end

    // R2: the stored code holds while code_in sweeps
    code_in = 4'd9;
    tick();
    pass_en = 1'b0;
    for (int c = 0; c < 16; c++) begin
      code_in = 4'(15 - c);
      tick();
      chk("R2 hold", 9, 1'b0);
    end

    // R2: a code presented on the same edge pass_en drops is not taken
    pass_en = 1'b1; code_in = 4'd6;
    tick();
    pass_en = 1'b0; code_in = 4'd13;
    tick();
    chk("R2 falling pass", 6, 1'b0);

    // R6: blanking overrides both while loading and while holding
    blank = 1'b1; pass_en = 1'b1; code_in = 4'd5;
    tick();
    chk("R6 blank while loading", 0, 1'b1);
    pass_en = 1'b0; code_in = 4'd14;
    tick();
    chk("R6 blank while holding", 0, 1'b1);

    // R7: the code loaded under blanking survives it
    blank = 1'b0;
    tick();
    chk("R7 code kept through blank", 5, 1'b0);

    // R7: blanking a held code, then releasing it
    pass_en = 1'b1; code_in = 4'd3;
    tick();
    pass_en = 1'b0; blank = 1'b1;
    for (int c = 0; c < 4; c++) begin
      code_in = 4'(c * 4);
      tick();
    end
    chk("R6 blank held", 0, 1'b1);
    blank = 1'b0;
    tick();
    chk("R7 release shows held code", 3, 1'b0);

    // R8: a reset in mid-run clears the stored code
    pass_en = 1'b1; code_in = 4'd15;
    tick();
    pass_en = 1'b0; rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    chk("R8 mid-run reset", 0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule